// File: doc/BRIEF.md
# Event-Driven Sampling Rate Timer

This timer sits beside a digitizer and decides how fast it samples. Event words of 16 bits arrive from a central sequencer with a one-cycle valid strobe. Each word is compared against a bank of programmable match slots. When an enabled slot matches, the timer opens an acquisition window. While the window is open, the sample enable follows a fast divider. When the programmed window length has run out, the sample enable returns to the slower base divider. A matching event also starts a per-slot delay counter that issues a one-cycle trigger pulse. Each matched event produces a record holding the time tag, the code, the slot and the rate that was in force.

Some runs follow a schedule that is known in advance. For these, a schedule compare opens windows at programmed time-tag values, either once or at a fixed period, with no live event needed. All timing comes from one reference clock. The time tag is a free-running count of reference clock cycles since reset.

Configuration uses a simple write port, with one register per address. Addresses 0..NCH-1 hold the match slots: bits 15:0 are the code and bit 16 is the slot enable. Addresses NCH..2*NCH-1 hold the slot delays. The next six addresses hold, in order: the window length, the base divider, the fast divider, the schedule time, the schedule period and the schedule enable (bit 0). With the default NCH of 8, these are addresses 16 to 21.

Top module: `evt_rate_timer`

## Requirements
- R1: While reset is held and on leaving it, fast_mode, trig and rec_valid are all low. The time tag restarts from 0 and then increases by one on every clock edge.
- R2: An event is a match when evt_valid is high and evt_code equals the code of a slot whose enable bit is set. A match produces rec_valid high for one cycle after the sampling edge. rec_code carries the code and rec_slot carries the lowest matching slot index.
- R3: An event is ignored when evt_valid is low, when its code matches no slot, or when it matches only disabled slots. An ignored event produces no record, opens no window and fires no trigger.
- R4: After the edge that samples a match, fast_mode is high for exactly the number of cycles in the window-length register, and then it returns low.
- R5: A match that arrives while a window is open restarts the window at full length, and fast_mode does not drop in between. Every matched event still gets its own record.
- R6: samp_en pulses once every base-divider cycles outside a window and once every fast-divider cycles inside a window. It is high in the first cycle after every rate switch.
- R7: Every slot that matches an event fires its trig bit for exactly one cycle. The pulse comes d+1 edges after the sampling edge, where d is that slot's delay register. A match while the slot's delay counter is running reloads the counter.
- R8: rec_tag holds the time-tag value of the cycle in which the event was presented. rec_fast is 1 if a window was already open when the event arrived.
- R9: When the schedule is enabled, a window opens at the edge where the time tag equals the schedule time, and no record is produced. The schedule time then advances by the schedule period. A period of zero clears the schedule enable, so the window is a one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Event word strobe |
| evt_code | input | 16 | Received event word |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| samp_en | output | 1 | Sample enable pulse to the digitizer |
| fast_mode | output | 1 | High while an acquisition window is open |
| trig | output | 8 | Per-slot delayed trigger pulses |
| rec_valid | output | 1 | Event record strobe |
| rec_code | output | 16 | Recorded event code |
| rec_slot | output | 3 | Lowest matching slot index |
| rec_tag | output | 32 | Time tag of the event |
| rec_fast | output | 1 | Window was already open at the event |

## Verification
A wrong window counter shows at the ports within one window length. In that case fast_mode falls early or late against the bench's own cycle count. A slip in the divider shows within one sample period, as a samp_en pulse that is missing or arrives out of phase at a rate switch. Corrupted slot or delay state shows as a missing or misplaced trig pulse within d+2 cycles of the event. A stale time tag shows at once in rec_tag against the bench's own count.

// File: rtl/evt_rate_timer.sv
module evt_rate_timer #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int DW  = 16,
  parameter int WW  = 24,
  parameter int VW  = 16,
  parameter int TW  = 32,
  parameter int AW  = 5,
  localparam int SW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_valid,
  input  logic [CW-1:0]  evt_code,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic           samp_en,
  output logic           fast_mode,
  output logic [NCH-1:0] trig,
  output logic           rec_valid,
  output logic [CW-1:0]  rec_code,
  output logic [SW-1:0]  rec_slot,
  output logic [TW-1:0]  rec_tag,
  output logic           rec_fast
);
  localparam int A_WIN  = 2*NCH;
  localparam int A_BDIV = 2*NCH + 1;
  localparam int A_FDIV = 2*NCH + 2;
  localparam int A_STIM = 2*NCH + 3;
  localparam int A_SPER = 2*NCH + 4;
  localparam int A_SEN  = 2*NCH + 5;

  logic [NCH-1:0] hitv;
  logic           evt_hit, sched_hit, load, win_end;
  logic [SW-1:0]  hit_slot;
  logic [TW-1:0]  tag;
  logic [WW-1:0]  win_q, win_left;
  logic [VW-1:0]  bdiv_q, fdiv_q, div_cnt, cur_div, reload;
  logic [TW-1:0]  stime_q, sper_q;
  logic           sen_q;

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic [CW:0]   match_q;
    logic [DW-1:0] dly_q, dcnt;
    logic          armed, pulse;

    assign hitv[i] = evt_valid && match_q[CW] && (match_q[CW-1:0] == evt_code);
    assign trig[i] = pulse;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        match_q <= '0;
        dly_q   <= '0;
        dcnt    <= '0;
        armed   <= 1'b0;
        pulse   <= 1'b0;
      end else begin
        pulse <= 1'b0;
        if (cfg_we && cfg_addr == AW'(i))       match_q <= cfg_wdata[CW:0];
        if (cfg_we && cfg_addr == AW'(NCH + i)) dly_q   <= cfg_wdata[DW-1:0];
        if (hitv[i]) begin
          armed <= 1'b1;
          dcnt  <= dly_q;
        end else if (armed) begin
          if (dcnt == '0) begin
            pulse <= 1'b1;
            armed <= 1'b0;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    hit_slot = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (hitv[i]) hit_slot = SW'(i);
  end

  assign evt_hit   = |hitv;
  assign sched_hit = sen_q && (tag == stime_q);
  assign load      = evt_hit || sched_hit;
  assign win_end   = (win_left == WW'(1)) && !load;
  assign fast_mode = (win_left != '0);
  assign samp_en   = (div_cnt == '0);
  assign cur_div   = fast_mode ? fdiv_q : bdiv_q;
  assign reload    = (cur_div == '0) ? '0 : cur_div - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag      <= '0;
      win_q    <= '0;
      bdiv_q   <= '0;
      fdiv_q   <= '0;
      stime_q  <= '0;
      sper_q   <= '0;
      sen_q    <= 1'b0;
      win_left <= '0;
      div_cnt  <= '0;
    end else begin
      tag <= tag + 1'b1;

      if (load)                win_left <= win_q;
      else if (fast_mode)      win_left <= win_left - 1'b1;

      if (load || win_end)     div_cnt <= '0;
      else if (div_cnt == '0)  div_cnt <= reload;
      else                     div_cnt <= div_cnt - 1'b1;

      if (sched_hit) begin
        stime_q <= stime_q + sper_q;
        if (sper_q == '0) sen_q <= 1'b0;
      end

      if (cfg_we) begin
        if (cfg_addr == AW'(A_WIN))  win_q   <= cfg_wdata[WW-1:0];
        if (cfg_addr == AW'(A_BDIV)) bdiv_q  <= cfg_wdata[VW-1:0];
        if (cfg_addr == AW'(A_FDIV)) fdiv_q  <= cfg_wdata[VW-1:0];
        if (cfg_addr == AW'(A_STIM)) stime_q <= cfg_wdata[TW-1:0];
        if (cfg_addr == AW'(A_SPER)) sper_q  <= cfg_wdata[TW-1:0];
        if (cfg_addr == AW'(A_SEN))  sen_q   <= cfg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_code  <= '0;
      rec_slot  <= '0;
      rec_tag   <= '0;
      rec_fast  <= 1'b0;
    end else begin
      rec_valid <= evt_hit;
      if (evt_hit) begin
        rec_code <= evt_code;
        rec_slot <= hit_slot;
        rec_tag  <= tag;
        rec_fast <= fast_mode;
      end
    end
  end
endmodule

// File: rtl/evt_rate_timer_chk.sv
module evt_rate_timer_chk #(
  parameter int VW = 16,
  parameter int WW = 24,
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_hit,
  input logic          samp_en,
  input logic          fast_mode,
  input logic          rec_valid,
  input logic [TW-1:0] rec_tag,
  input logic [VW-1:0] bdiv_q,
  input logic [WW-1:0] win_q
);
  // R2
  match_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> rec_valid);

  // R4
  match_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && win_q != '0) |=> fast_mode);

  // R6
  rise_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_mode) |-> samp_en);

  // R6
  fall_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_mode) |-> samp_en);

  // R6
  base_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && !fast_mode && bdiv_q > VW'(1)) |=> (!samp_en || fast_mode));

  // R8
  tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && $past(rec_valid)) |-> rec_tag == $past(rec_tag) + 1'b1);
endmodule

bind evt_rate_timer evt_rate_timer_chk #(.VW(VW), .WW(WW), .TW(TW)) i_chk (
  .clk(clk), .rst_n(rst_n), .evt_hit(evt_hit), .samp_en(samp_en),
  .fast_mode(fast_mode), .rec_valid(rec_valid), .rec_tag(rec_tag),
  .bdiv_q(bdiv_q), .win_q(win_q)
);

// File: tb/test_evt_rate_timer.sv
module test_evt_rate_timer;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [15:0] evt_code;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        samp_en, fast_mode, rec_valid, rec_fast;
  logic [7:0]  trig;
  logic [15:0] rec_code;
  logic [2:0]  rec_slot;
  logic [31:0] rec_tag;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] cyc;

  always #(PERIOD/2) clk = ~clk;

  evt_rate_timer i_evt_rate_timer (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .samp_en(samp_en), .fast_mode(fast_mode), .trig(trig),
    .rec_valid(rec_valid), .rec_code(rec_code), .rec_slot(rec_slot),
    .rec_tag(rec_tag), .rec_fast(rec_fast)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1;
  end

  // {pad3, valid, code16, expect_record, expect_slot3, trigger_mask8}
  localparam logic [31:0] VEC [6] = '{
    {3'b0, 1'b1, 16'h1111, 1'b1, 3'd0, 8'h01},
    {3'b0, 1'b1, 16'h2222, 1'b1, 3'd1, 8'h06},
    {3'b0, 1'b1, 16'hABCD, 1'b0, 3'd0, 8'h00},
    {3'b0, 1'b1, 16'h7777, 1'b0, 3'd0, 8'h00},
    {3'b0, 1'b0, 16'h1111, 1'b0, 3'd0, 8'h00},
    {3'b0, 1'b1, 16'h2222, 1'b1, 3'd1, 8'h06}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic v, input logic [15:0] c);
    evt_valid = v; evt_code = c;
    step();
    evt_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0]  seen;
    logic [31:0] t1, at;
    int          cnt;
    logic        stayed;
    rst_n = 1'b0; evt_valid = 1'b0; evt_code = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) step();
    chk("R1 fast_mode in reset", fast_mode, 0);
    chk("R1 trig in reset", trig, 0);
    chk("R1 rec_valid in reset", rec_valid, 0);
    rst_n = 1'b1;
    step();

    wr(0, 32'h0001_1111);
    wr(1, 32'h0001_2222);
    wr(2, 32'h0001_2222);
    wr(5, 32'h0000_ABCD);
    wr(8, 3);
    wr(9, 0);
    wr(10, 5);
    wr(16, 10);
    wr(17, 4);
    wr(18, 2);
    repeat (5) step();

    for (int v = 0; v < 6; v++) begin
      send(VEC[v][28], VEC[v][27:12]);
      chk("R2/R3 record strobe", rec_valid, VEC[v][11]);
      chk("R4/R3 window opened", fast_mode, VEC[v][11]);
      if (VEC[v][11]) begin
        chk("R2 record slot", rec_slot, VEC[v][10:8]);
        chk("R2 record code", rec_code, VEC[v][27:12]);
        chk("R8 record tag", rec_tag, cyc - 1);
        chk("R8 rate in force", rec_fast, 0);
      end
      seen = '0;
      for (int i = 0; i < 25; i++) begin
        seen |= trig;
        step();
      end
      chk("R7/R3 triggers fired", seen, VEC[v][7:0]);
    end

    send(1'b1, 16'h1111);
    repeat (3) step();
    chk("R7 trigger not yet", trig[0], 0);
    step();
    chk("R7 trigger at d+1", trig[0], 1);
    step();
    chk("R7 trigger one cycle", trig[0], 0);
    repeat (30) step();

    send(1'b1, 16'h1111);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      if (samp_en) cnt++;
      if (i == 9) chk("R4 last window cycle", fast_mode, 1);
      step();
    end
    chk("R4 window closed", fast_mode, 0);
    chk("R6 fast sample count", cnt, 5);
    chk("R6 sample at return", samp_en, 1);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      if (samp_en) cnt++;
      step();
    end
    chk("R6 base sample count", cnt, 2);
    repeat (30) step();

    send(1'b1, 16'h1111);
    t1 = rec_tag;
    stayed = 1'b1;
    for (int i = 0; i < 5; i++) begin
      stayed &= fast_mode;
      step();
    end
    send(1'b1, 16'h1111);
    chk("R5 second record", rec_valid, 1);
    chk("R5 record tag spacing", rec_tag - t1, 6);
    chk("R8 rate in force inside window", rec_fast, 1);
    for (int i = 0; i < 9; i++) begin
      step();
      stayed &= fast_mode;
    end
    chk("R5 window held across restart", stayed, 1);
    step();
    chk("R5 restarted window closed", fast_mode, 0);
    repeat (30) step();

    at = cyc + 20;
    wr(19, at);
    wr(20, 0);
    wr(21, 1);
    while (cyc < at) step();
    chk("R9 before schedule time", fast_mode, 0);
    step();
    chk("R9 scheduled window", fast_mode, 1);
    chk("R9 no record", rec_valid, 0);
    repeat (40) step();
    chk("R9 one-shot", fast_mode, 0);

    at = cyc + 20;
    wr(19, at);
    wr(20, 15);
    wr(21, 1);
    while (cyc < at + 1) step();
    chk("R9 periodic first", fast_mode, 1);
    while (cyc < at + 15) step();
    chk("R9 gap between windows", fast_mode, 0);
    step();
    chk("R9 periodic second", fast_mode, 1);
    wr(21, 0);
    repeat (20) step();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule